// File: doc/BRIEF.md
# Streaming Parallel Interference Cancellation Stage

This block is one stage of a multistage parallel interference canceller for an asynchronous CDMA base-station receiver. It works on one bit index at a time instead of on a detection window. For each index it takes the matched-filter soft values of all users and the hard decisions that an earlier stage made for that index. For each user it subtracts the interference that the other users' neighbouring bits cause. It then produces a cleaned soft value and a new hard decision for that index.

Users are asynchronous, so the interference on bit i of a user comes only from bits i-1, i and i+1 of the others. The stage therefore stores three small K-by-K coefficient blocks, one for each relative bit offset. A decision is ±1, so every coefficient is simply added or subtracted and no multiplier is needed. Index i is emitted when index i+1 arrives. The output stream has the same form as the input stream, so several stages can be cascaded behind a causal matched filter, each stage working on a different bit index at the same time. The coefficients are loaded through a write port while no stream data is being presented.

Top module: `xcancel_stage`

## Requirements
- R1: After reset `outValid` is 0 and every stored coefficient is zero, so with no coefficient writes each emitted soft value equals the soft value that was presented for that index.
- R2: The result for index i is registered at the clock edge that samples index i+1 (`inValid` high). `outValid` is high for exactly the one cycle after that edge. Nothing is emitted for the most recent index until the next index arrives.
- R3: Decision bits encode 0 as +1 and 1 as -1. The emitted soft value for user k is soft_k(i) - Σ_j [E(k,j)·d_j(i-1) + S(k,j)·d_j(i) + L(k,j)·d_j(i+1)]. E, S and L are the coefficient blocks for offsets -1, 0 and +1. Soft values sit in `inSoft`/`outSoft` at bits [16k+15:16k]. Decision bits sit in bit k of `inDec`/`outDec`.
- R4: The first index after reset, and any index presented with `inFirst` high, starts a stream. For the first emitted index of a stream the i-1 term contributes zero.
- R5: An index presented with `inFirst` high discards the pending index of the previous stream, which is never emitted. `outValid` stays low in the following cycle.
- R6: The sum is formed at full precision and then saturated once to the 16-bit signed range [-32768, 32767].
- R7: Each emitted decision bit is 1 exactly when that user's emitted soft value is negative.
- R8: Writes to the diagonal of the offset-0 block (row equal to column) are ignored, so a user's own current bit never cancels itself.
- R9: A coefficient write (`cfgWe` high) stores 16-bit signed `cfgData` into block `cfgBlk`, row `cfgRow` (victim user k) and column `cfgCol` (source user j). The block codes are 0 for offset -1, 1 for offset 0 and 2 for offset +1. Code 3 changes nothing.
- R10: A coefficient write in a cycle where `inValid` is high is ignored.
- R11: Cycles with `inValid` low change no stream state and emit nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Qualifies one bit index on inSoft/inDec/inFirst |
| inFirst | input | 1 | Marks the first index of a new stream |
| inSoft | input | 64 | Matched-filter soft values, 16 bits per user |
| inDec | input | 4 | Earlier-stage decisions for this index, 1 = negative |
| cfgWe | input | 1 | Coefficient write strobe |
| cfgBlk | input | 2 | Coefficient block: 0 offset -1, 1 offset 0, 2 offset +1 |
| cfgRow | input | 2 | Victim user index |
| cfgCol | input | 2 | Source user index |
| cfgData | input | 16 | Signed coefficient value |
| outValid | output | 1 | Qualifies one emitted index |
| outSoft | output | 64 | Cleaned soft values, 16 bits per user |
| outDec | output | 4 | New hard decisions, 1 = negative |

## Verification
The assertions assume that every input has a defined value on every clock edge after reset and that `inFirst` only has meaning while `inValid` is high. They also assume that a stream's decisions for index i+1 arrive together with its index i+1 and not later. The bench drives every input at the falling edge from concrete values. It raises `inFirst` only with `inValid`, and it inserts idle gaps and coefficient writes only between whole indices. The one deliberate exception is a write made during a valid cycle, which tests that such a write is ignored. The reference model tracks each stream in queues and predicts every cycle's output from the requirement formula.

// File: rtl/xcancel_pkg.sv
package xcancel_pkg;

  // Coefficient block select codes; the value is the bit offset + 1.
  typedef enum logic [1:0] {
    BLK_EARLY = 2'd0,
    BLK_SAME  = 2'd1,
    BLK_LATE  = 2'd2,
    BLK_NONE  = 2'd3
  } blkSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic shift;     // sample a new bit index into the history
    logic emit;      // register a result for the pending index
    logic coefWr;    // commit the presented coefficient write
    logic prevLive;  // the i-1 neighbour of the pending index exists
  } ctrlStrobe_t;

endpackage

// File: rtl/xcancel_ctrl.sv
module xcancel_ctrl
  import xcancel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        inFirst,
  input  logic        cfgWe,
  input  logic [1:0]  cfgBlk,
  output ctrlStrobe_t strb
);

  logic haveCur;   // a pending index waits for its look-ahead neighbour
  logic havePrev;  // the pending index has a predecessor in its stream

  always_comb begin
    strb.shift    = inValid;
    strb.emit     = inValid && haveCur && !inFirst;
    strb.coefWr   = cfgWe && !inValid && (cfgBlk != BLK_NONE);
    strb.prevLive = havePrev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      haveCur  <= 1'b0;
      havePrev <= 1'b0;
    end else if (inValid) begin
      haveCur  <= 1'b1;
      havePrev <= inFirst ? 1'b0 : haveCur;
    end
  end

  // A restarted stream never sees a stale i-1 neighbour.
  assert_restart_noprev_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inFirst) |=> !strb.prevLive);

  // An idle cycle leaves the stream history alone.
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(haveCur) && $stable(havePrev)));

endmodule

// File: rtl/xcancel_dp.sv
module xcancel_dp
  import xcancel_pkg::*;
#(
  parameter int NUSR = 4,
  parameter int SW   = 16,
  parameter int CW   = 16,
  localparam int RW  = (NUSR > 1) ? $clog2(NUSR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobe_t          strb,
  input  logic [NUSR*SW-1:0]   inSoft,
  input  logic [NUSR-1:0]      inDec,
  input  logic [1:0]           cfgBlk,
  input  logic [RW-1:0]        cfgRow,
  input  logic [RW-1:0]        cfgCol,
  input  logic [CW-1:0]        cfgData,
  output logic                 outValid,
  output logic [NUSR*SW-1:0]   outSoft,
  output logic [NUSR-1:0]      outDec
);

  localparam int NBLK = 3;
  localparam int WMAX = (SW > CW) ? SW : CW;
  localparam int AW   = WMAX + $clog2(NBLK * NUSR) + 2;
  localparam logic signed [AW-1:0] MAXV = {{(AW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-SW+1){1'b1}}, {(SW-1){1'b0}}};

  // Coefficient storage: [block][victim][source]
  logic signed [CW-1:0] coefMem [NBLK][NUSR][NUSR];

  // Stream history: decisions for i-1 and i, soft values for i
  logic [NUSR-1:0]    decPrev, decCur;
  logic [NUSR*SW-1:0] softCur;

  function automatic logic signed [AW-1:0] signedTerm(input logic negBit,
                                                      input logic signed [CW-1:0] c);
    logic signed [AW-1:0] e;
    e = {{(AW-CW){c[CW-1]}}, c};
    return negBit ? -e : e;
  endfunction

  function automatic logic signed [SW-1:0] clampSoft(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] r;
    if (a > MAXV)      r = MAXV;
    else if (a < MINV) r = MINV;
    else               r = a;
    return r[SW-1:0];
  endfunction

  // Coefficient write decode, one register per entry
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    for (genvar r = 0; r < NUSR; r++) begin : g_row
      for (genvar c = 0; c < NUSR; c++) begin : g_col
        localparam bit SELF = (b == 1) && (r == c);
        logic hit;
        assign hit = strb.coefWr && (cfgBlk == 2'(b)) &&
                     (cfgRow == RW'(r)) && (cfgCol == RW'(c)) && !SELF;
        always_ff @(posedge clk) begin
          if (!rst_n)   coefMem[b][r][c] <= '0;
          else if (hit) coefMem[b][r][c] <= cfgData;
        end

        assert_coef_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
          strb.shift |=> $stable(coefMem[b][r][c]));

        if (SELF) begin : g_self
          assert_self_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            coefMem[b][r][c] == '0);
        end
      end
    end
  end

  // History shift on every accepted index
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decPrev <= '0;
      decCur  <= '0;
      softCur <= '0;
    end else if (strb.shift) begin
      decPrev <= decCur;
      decCur  <= inDec;
      softCur <= inSoft;
    end
  end

  // Per-user cancellation: add/subtract only
  logic signed [SW-1:0] cleanSoft [NUSR];

  for (genvar k = 0; k < NUSR; k++) begin : g_usr
    logic signed [AW-1:0] acc;
    logic signed [SW-1:0] own;
    assign own = softCur[k*SW +: SW];

    always_comb begin
      acc = {{(AW-SW){own[SW-1]}}, own};
      for (int j = 0; j < NUSR; j++) begin
        if (strb.prevLive)
          acc = acc - signedTerm(decPrev[j], coefMem[0][k][j]);
        acc = acc - signedTerm(decCur[j], coefMem[1][k][j]);
        acc = acc - signedTerm(inDec[j],  coefMem[2][k][j]);
      end
    end

    assign cleanSoft[k] = clampSoft(acc);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        outSoft[k*SW +: SW] <= '0;
        outDec[k]           <= 1'b0;
      end else if (strb.emit) begin
        outSoft[k*SW +: SW] <= cleanSoft[k];
        outDec[k]           <= cleanSoft[k][SW-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= strb.emit;
  end

endmodule

// File: rtl/xcancel_stage.sv
module xcancel_stage
  import xcancel_pkg::*;
#(
  parameter int NUSR = 4,
  parameter int SW   = 16,
  parameter int CW   = 16,
  localparam int RW  = (NUSR > 1) ? $clog2(NUSR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic                inFirst,
  input  logic [NUSR*SW-1:0]  inSoft,
  input  logic [NUSR-1:0]     inDec,
  input  logic                cfgWe,
  input  logic [1:0]          cfgBlk,
  input  logic [RW-1:0]       cfgRow,
  input  logic [RW-1:0]       cfgCol,
  input  logic [CW-1:0]       cfgData,
  output logic                outValid,
  output logic [NUSR*SW-1:0]  outSoft,
  output logic [NUSR-1:0]     outDec
);

  ctrlStrobe_t strb;

  xcancel_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .inFirst (inFirst),
    .cfgWe   (cfgWe),
    .cfgBlk  (cfgBlk),
    .strb    (strb)
  );

  xcancel_dp #(.NUSR(NUSR), .SW(SW), .CW(CW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .inSoft   (inSoft),
    .inDec    (inDec),
    .cfgBlk   (cfgBlk),
    .cfgRow   (cfgRow),
    .cfgCol   (cfgCol),
    .cfgData  (cfgData),
    .outValid (outValid),
    .outSoft  (outSoft),
    .outDec   (outDec)
  );

  // Output only in the cycle after an accepted index.
  assert_out_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid));

  // A stream restart drops the pending index.
  assert_restart_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inFirst) |=> !outValid);

  for (genvar k = 0; k < NUSR; k++) begin : g_chk
    assert_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
      outValid |-> (outDec[k] == outSoft[k*SW + SW - 1]));
  end

endmodule

// File: tb/xcancel_stage_tb.sv
module xcancel_stage_tb;

  localparam int K = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0, inFirst = 1'b0, cfgWe = 1'b0;
  logic [63:0] inSoft = '0;
  logic [3:0]  inDec = '0;
  logic [1:0]  cfgBlk = '0, cfgRow = '0, cfgCol = '0;
  logic [15:0] cfgData = '0;
  logic        outValid;
  logic [63:0] outSoft;
  logic [3:0]  outDec;

  always #10 clk = ~clk;

  xcancel_stage u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inFirst(inFirst),
    .inSoft(inSoft), .inDec(inDec), .cfgWe(cfgWe), .cfgBlk(cfgBlk),
    .cfgRow(cfgRow), .cfgCol(cfgCol), .cfgData(cfgData),
    .outValid(outValid), .outSoft(outSoft), .outDec(outDec)
  );

  typedef int vec_t [K];

  int     nVec = 0, nBad = 0;
  bit     finished = 0;
  int     cm [3][K][K];
  vec_t   sq [$];
  bit [3:0] dq [$];

  function automatic int pm(bit b);
    return b ? -1 : 1;
  endfunction

  task automatic fail(string tag, string what, int act, int exp);
    nBad++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  // One clock cycle: drive at a falling edge, check at the next one.
  task automatic cyc(bit v, bit f, vec_t s, bit [3:0] d,
                     bit we, int blk, int row, int col, int val, string tag);
    bit   expV;
    vec_t expS;
    bit [3:0] expD;
    expV = 0;
    expD = '0;
    foreach (expS[k]) expS[k] = 0;
    inValid = v; inFirst = f; inDec = d;
    for (int k = 0; k < K; k++) inSoft[k*16 +: 16] = 16'(s[k]);
    cfgWe = we; cfgBlk = 2'(blk); cfgRow = 2'(row); cfgCol = 2'(col); cfgData = 16'(val);
    if (v) begin
      if (f) begin sq.delete(); dq.delete(); end
      sq.push_back(s);
      dq.push_back(d);
      if (sq.size() >= 2) begin
        int t;
        t = sq.size() - 2;
        expV = 1;
        for (int k = 0; k < K; k++) begin
          longint a;
          a = sq[t][k];
          for (int j = 0; j < K; j++) begin
            if (t >= 1) a -= pm(dq[t-1][j]) * cm[0][k][j];
            if (j != k) a -= pm(dq[t][j]) * cm[1][k][j];
            a -= pm(dq[t+1][j]) * cm[2][k][j];
          end
          if (a > 32767) a = 32767;
          if (a < -32768) a = -32768;
          expS[k] = int'(a);
          expD[k] = (a < 0);
        end
      end
      if (sq.size() > 3) begin void'(sq.pop_front()); void'(dq.pop_front()); end
    end else if (we && blk < 3) begin
      cm[blk][row][col] = val;
    end
    @(posedge clk);
    @(negedge clk);
    nVec++;
    if (outValid !== expV) fail(tag, "outValid", int'(outValid), int'(expV));
    else if (expV) begin
      for (int k = 0; k < K; k++) begin
        if ($signed(outSoft[k*16 +: 16]) != expS[k])
          fail(tag, $sformatf("soft[%0d]", k), int'($signed(outSoft[k*16 +: 16])), expS[k]);
        if (outDec[k] !== expD[k])
          fail(tag, $sformatf("dec[%0d]", k), int'(outDec[k]), int'(expD[k]));
      end
    end
  endtask

  task automatic idle(string tag);
    vec_t z;
    foreach (z[k]) z[k] = 0;
    cyc(0, 0, z, '0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(int blk, int row, int col, int val, string tag);
    vec_t z;
    foreach (z[k]) z[k] = 0;
    cyc(0, 0, z, '0, 1, blk, row, col, val, tag);
  endtask

  task automatic sym(bit f, string tag);
    vec_t s;
    bit [3:0] d;
    foreach (s[k]) begin
      s[k] = int'($urandom_range(0, 40000)) - 20000;
      d[k] = (s[k] < 0);
    end
    cyc(1, f, s, d, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fixedSym(bit f, int sv, bit [3:0] d, string tag);
    vec_t s;
    foreach (s[k]) s[k] = sv;
    cyc(1, f, s, d, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    foreach (cm[b, r, c]) cm[b][r][c] = 0;
    repeat (3) @(negedge clk);
    nVec++;
    if (outValid !== 1'b0) fail("R1", "outValid in reset", int'(outValid), 0);
    rst_n = 1'b1;

    // R1 R2: zero coefficients pass soft values through, one index of look-ahead
    for (int n = 0; n < 6; n++) sym(0, "R1 R2");
    idle("R11");
    idle("R11");
    sym(0, "R2 R11");

    // R9 R8: load all three blocks, including non-zero same-offset diagonals
    for (int b = 0; b < 3; b++)
      for (int r = 0; r < K; r++)
        for (int c = 0; c < K; c++)
          wr(b, r, c, int'($urandom_range(0, 6000)) - 3000, "R9 R8");
    wr(3, 1, 2, 12345, "R9");

    // R3 R4 R7 R11: streams with restarts and gaps
    for (int rep = 0; rep < 40; rep++) begin
      sym(1, "R4 R5");
      for (int n = 0; n < 12; n++) begin
        sym(0, "R3 R7");
        if ($urandom_range(0, 3) == 0) idle("R11");
      end
    end

    // R5: restart right after a single index
    sym(1, "R5");
    sym(1, "R5");
    sym(0, "R4");

    // R10: a write during a valid cycle is ignored
    begin
      vec_t s;
      foreach (s[k]) s[k] = 1000;
      cyc(1, 0, s, 4'b0101, 1, 2, 0, 1, 20000, "R10");
      for (int n = 0; n < 6; n++) sym(0, "R10");
    end

    // R6: saturation at both ends
    for (int b = 0; b < 3; b++)
      for (int r = 0; r < K; r++)
        for (int c = 0; c < K; c++)
          wr(b, r, c, 30000, "R6");
    fixedSym(1, 30000, 4'b1111, "R6");
    fixedSym(0, 30000, 4'b1111, "R6 R7");
    fixedSym(0, 30000, 4'b1111, "R6 R7");
    fixedSym(0, -30000, 4'b0000, "R6 R7");
    fixedSym(0, -30000, 4'b0000, "R6 R7");
    fixedSym(0, 0, 4'b1010, "R6");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule